// File: doc/BRIEF.md
# Finite-Set Predictive Level Selector

This block picks, once per sampling period, which of five output voltage levels a two-capacitor series module should apply next. On an accepted start strobe it captures the sampled load current, both measured capacitor voltages and the current reference. It then runs a one-step forward-Euler model of the resistive-inductive load for each candidate level and scores every predicted current by its weighted absolute distance from the reference. The code of the cheapest candidate is presented with a one-cycle done pulse.

The model gains are elaboration constants: `K_STEP` stands for the sampling period divided by the inductance, and `K_DAMP` stands for the resistance times that ratio. Both are unsigned fixed-point numbers with `GF` fractional bits, and `WEIGHT` is the cost weighting factor. Candidates go through one shared multiplier, one per clock, so a decision takes five clocks after the start is taken. That is far inside a 12 kHz sampling period at any practical clock.

Top module: `fcs_level_picker`

## Requirements
- R1: The candidate codes and their voltages are 0 = +vc1, 1 = +(vc1+vc2), 2 = −vc1, 3 = −(vc1+vc2) and 4 = 0. The voltages are built from the captured measured capacitor voltages, as signed IW+1-bit values.
- R2: For a candidate voltage v, the prediction is i − ⌊K_DAMP·i / 2^GF⌋ + ⌊K_STEP·v / 2^GF⌋. It is computed without loss in a wide signed format and uses floor (arithmetic right shift) rounding.
- R3: A candidate's cost is WEIGHT·|pred − i_ref|. The absolute error is an IW+1-bit unsigned value and the cost is exact, with no truncation.
- R4: The output level is the candidate with the smallest cost. When costs are equal, the lowest code wins.
- R5: A start seen high at a clock edge while the block is idle captures all four inputs at that edge. The done output is then high for exactly one cycle, starting at the fifth edge after the capture edge, and the new level appears at that same edge.
- R6: A start seen at any of the five edges that follow an accepted start is ignored. The block's inputs are also ignored during that window: neither affects the pending result or the number of done pulses. A start held high is therefore accepted every sixth edge.
- R7: The level output only ever takes the values 0 to 4, and it changes only at an edge that raises done.
- R8: A synchronous active-high reset sets the level to 4 (zero voltage) and clears done, and it abandons any evaluation in flight.
- R9: A prediction outside the signed IW-bit range is clamped to the most positive or most negative value, and it never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request one evaluation |
| i_meas_i | input | IW | Sampled load current, signed |
| vc1_i | input | IW | First capacitor voltage, signed |
| vc2_i | input | IW | Second capacitor voltage, signed |
| i_ref_i | input | IW | Current reference, signed |
| level_o | output | 3 | Chosen level code (0 to 4) |
| done_o | output | 1 | One-cycle pulse when level_o is updated |

## Verification
The hardest situations to reach from the ports are exact cost ties and clamped predictions. Random inputs almost never land a reference exactly midway between two predictions, or push the model past the signed range. The stimulus therefore uses equal capacitor voltages and a gain that maps them to evenly spaced predictions, and puts the reference exactly between two of them. A further set drives full-scale capacitor voltages against a near-full-scale current so that the predictions clamp. A second hard case is a start that arrives while an evaluation is running: it is driven together with fresh inputs in the middle of an evaluation, and also by holding the start high for many cycles.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;

    // number of candidate voltage levels evaluated per decision
    localparam int unsigned N_CAND = 5;

    typedef logic [2:0] lvl_code_t;

    // code of the zero-voltage candidate, also the reset value
    localparam lvl_code_t LVL_ZERO = 3'd4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } fcs_state_e;

    // how a candidate voltage is built from the two capacitor voltages
    typedef struct packed {
        logic is_zero;
        logic negate;
        logic add_second;
    } cand_sel_t;

    function automatic cand_sel_t cand_decode(lvl_code_t code);
        cand_sel_t s;
        s = '0;
        case (code)
            3'd0: s = '0;
            3'd1: s.add_second = 1'b1;
            3'd2: s.negate = 1'b1;
            3'd3: begin
                s.negate     = 1'b1;
                s.add_second = 1'b1;
            end
            default: s.is_zero = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fcs_seq.sv
`timescale 1ns/1ps
module fcs_seq
    import fcs_pkg::*;
#(
    parameter int unsigned NC = fcs_pkg::N_CAND
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      start_i,
    output logic      go_o,
    output logic      eval_o,
    output logic      first_o,
    output logic      last_o,
    output lvl_code_t idx_o
);

    localparam lvl_code_t LAST_IDX = lvl_code_t'(NC - 1);

    fcs_state_e state_q;
    lvl_code_t  idx_q;

    assign go_o    = start_i && (state_q == ST_IDLE);
    assign eval_o  = (state_q == ST_EVAL);
    assign first_o = (idx_q == '0);
    assign last_o  = (idx_q == LAST_IDX);
    assign idx_o   = idx_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_EVAL;
                        idx_q   <= '0;
                    end
                end
                ST_EVAL: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 3'd1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fcs_cand_cost.sv
`timescale 1ns/1ps
module fcs_cand_cost
    import fcs_pkg::*;
#(
    parameter int IW     = 16,
    parameter int GW     = 16,
    parameter int GF     = 12,
    parameter int AW     = 8,
    parameter int K_STEP = 1024,
    parameter int WEIGHT = 3
) (
    input  lvl_code_t                    idx_i,
    input  logic signed [IW-1:0]         vc1_i,
    input  logic signed [IW-1:0]         vc2_i,
    input  logic signed [IW+GW+1:0]      base_i,
    input  logic signed [IW-1:0]         ref_i,
    output logic        [IW+AW:0]        cost_o
);

    localparam int VW = IW + 1;
    localparam int PW = IW + GW + 2;
    localparam int EW = IW + 1;
    localparam int CW = EW + AW;
    localparam logic signed [PW-1:0] P_MAX = PW'((longint'(1) << (IW - 1)) - 1);
    localparam logic signed [PW-1:0] P_MIN = -P_MAX - PW'(1);

    cand_sel_t sel;
    assign sel = cand_decode(idx_i);

    // candidate voltage from the captured capacitor voltages
    logic signed [VW-1:0] a_w, b_w, pair, v_cand;
    assign a_w    = VW'(vc1_i);
    assign b_w    = VW'(vc2_i);
    assign pair   = sel.add_second ? (a_w + b_w) : a_w;
    assign v_cand = sel.is_zero ? '0 : (sel.negate ? -pair : pair);

    // shared multiplier: voltage step of the Euler model
    logic signed [PW-1:0] v_wide, step_k, prod, sum;
    assign v_wide = PW'(v_cand);
    assign step_k = PW'(K_STEP);
    assign prod   = v_wide * step_k;
    assign sum    = base_i + (prod >>> GF);

    logic signed [IW-1:0] pred;
    always_comb begin
        if (sum > P_MAX) begin
            pred = P_MAX[IW-1:0];
        end else if (sum < P_MIN) begin
            pred = P_MIN[IW-1:0];
        end else begin
            pred = sum[IW-1:0];
        end
    end

    // weighted absolute tracking error
    logic signed [EW-1:0] diff;
    logic        [EW-1:0] mag;
    assign diff   = EW'(pred) - EW'(ref_i);
    assign mag    = diff[EW-1] ? EW'(-diff) : EW'(diff);
    assign cost_o = CW'(mag) * CW'(WEIGHT);

endmodule

// File: rtl/fcs_argmin.sv
`timescale 1ns/1ps
module fcs_argmin
    import fcs_pkg::*;
#(
    parameter int CW = 25
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          eval_i,
    input  logic          first_i,
    input  logic          last_i,
    input  lvl_code_t     idx_i,
    input  logic [CW-1:0] cost_i,
    output lvl_code_t     level_o,
    output logic          done_o,
    output logic [CW-1:0] best_o
);

    logic [CW-1:0] best_q;
    lvl_code_t     bidx_q;
    logic          take;
    lvl_code_t     win;

    // strict compare keeps the earlier (lower) code on equal cost
    assign take   = first_i || (cost_i < best_q);
    assign win    = take ? idx_i : bidx_q;
    assign best_o = best_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            best_q  <= '0;
            bidx_q  <= LVL_ZERO;
            level_o <= LVL_ZERO;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (eval_i) begin
                if (take) begin
                    best_q <= cost_i;
                    bidx_q <= idx_i;
                end
                if (last_i) begin
                    level_o <= win;
                    done_o  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fcs_level_picker.sv
`timescale 1ns/1ps
module fcs_level_picker
    import fcs_pkg::*;
#(
    parameter int IW     = 16,
    parameter int GW     = 16,
    parameter int GF     = 12,
    parameter int AW     = 8,
    parameter int K_STEP = 1024,
    parameter int K_DAMP = 256,
    parameter int WEIGHT = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 start_i,
    input  logic signed [IW-1:0] i_meas_i,
    input  logic signed [IW-1:0] vc1_i,
    input  logic signed [IW-1:0] vc2_i,
    input  logic signed [IW-1:0] i_ref_i,
    output logic [2:0]           level_o,
    output logic                 done_o
);

    localparam int PW = IW + GW + 2;
    localparam int CW = IW + 1 + AW;

    logic      go, eval, first, last;
    lvl_code_t idx;

    fcs_seq #(.NC(N_CAND)) u_seq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .go_o    (go),
        .eval_o  (eval),
        .first_o (first),
        .last_o  (last),
        .idx_o   (idx)
    );

    // current-dependent part of the prediction, shared by all candidates
    logic signed [PW-1:0] i_wide, damp_k, damp_prod, base_d, base_q;
    assign i_wide    = PW'(i_meas_i);
    assign damp_k    = PW'(K_DAMP);
    assign damp_prod = i_wide * damp_k;
    assign base_d    = i_wide - (damp_prod >>> GF);

    logic signed [IW-1:0] vc1_q, vc2_q, ref_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            base_q <= '0;
            vc1_q  <= '0;
            vc2_q  <= '0;
            ref_q  <= '0;
        end else if (go) begin
            base_q <= base_d;
            vc1_q  <= vc1_i;
            vc2_q  <= vc2_i;
            ref_q  <= i_ref_i;
        end
    end

    logic [CW-1:0] cost;
    logic [CW-1:0] best_cost;
    lvl_code_t     level_q;

    fcs_cand_cost #(
        .IW(IW), .GW(GW), .GF(GF), .AW(AW), .K_STEP(K_STEP), .WEIGHT(WEIGHT)
    ) u_cost (
        .idx_i  (idx),
        .vc1_i  (vc1_q),
        .vc2_i  (vc2_q),
        .base_i (base_q),
        .ref_i  (ref_q),
        .cost_o (cost)
    );

    fcs_argmin #(.CW(CW)) u_argmin (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .eval_i  (eval),
        .first_i (first),
        .last_i  (last),
        .idx_i   (idx),
        .cost_i  (cost),
        .level_o (level_q),
        .done_o  (done_o),
        .best_o  (best_cost)
    );

    assign level_o = level_q;

endmodule

// File: rtl/fcs_level_picker_chk.sv
`timescale 1ns/1ps
module fcs_level_picker_chk #(
    parameter int CW = 25
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          go_i,
    input logic          eval_i,
    input logic          first_i,
    input logic          last_i,
    input logic          done_i,
    input logic [2:0]    level_i,
    input logic [CW-1:0] best_i
);

    // R7: only codes 0..4 ever leave the block
    a_r7_code_range: assert property (@(posedge clk_i) disable iff (rst_i)
        level_i <= 3'd4);

    // R7: the level moves only together with a done pulse
    a_r7_level_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(level_i) |-> done_i);

    // R5: done is a single-cycle pulse
    a_r5_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |=> !done_i);

    // R5: done is seen six sampled edges after an accepted start
    a_r5_done_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |-> $past(go_i, 6));

    // R6: a running evaluation is neither aborted nor restarted
    a_r6_no_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        (eval_i && !last_i) |=> (eval_i && !first_i));

    // R4: the running best cost never increases within an evaluation
    a_r4_best_nonincr: assert property (@(posedge clk_i) disable iff (rst_i)
        (eval_i && !first_i) |=> (best_i <= $past(best_i)));

    // R8: state right after reset
    a_r8_reset_state: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (level_i == 3'd4 && !done_i));

endmodule

bind fcs_level_picker fcs_level_picker_chk #(.CW(CW)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .go_i    (go),
    .eval_i  (eval),
    .first_i (first),
    .last_i  (last),
    .done_i  (done_o),
    .level_i (level_o),
    .best_i  (best_cost)
);

// File: tb/fcs_level_picker_tb.sv
`timescale 1ns/1ps
module fcs_level_picker_tb;

    localparam int  B_GF     = 12;
    localparam int  B_STEP   = 1024;
    localparam int  B_DAMP   = 256;
    localparam int  B_WEIGHT = 3;
    localparam longint B_ONE = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [15:0] i_in = '0, v1 = '0, v2 = '0, iref = '0;
    logic [2:0] level;
    logic done;

    int total = 0;
    int bad = 0;
    int n_done = 0;
    bit checking = 1'b0;
    string cur_tag = "R8";

    always #10 clk = ~clk;

    fcs_level_picker #(
        .IW(16), .GW(16), .GF(B_GF), .AW(8),
        .K_STEP(B_STEP), .K_DAMP(B_DAMP), .WEIGHT(B_WEIGHT)
    ) u_dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .i_meas_i (i_in),
        .vc1_i    (v1),
        .vc2_i    (v2),
        .i_ref_i  (iref),
        .level_o  (level),
        .done_o   (done)
    );

    function automatic longint floor_div(longint x);
        if (x >= 0) return x / B_ONE;
        return -((-x + B_ONE - 1) / B_ONE);
    endfunction

    // behavioural decision: R1 voltages, R2 Euler step, R9 clamp, R3 cost, R4 argmin
    function automatic int ref_pick(int ci, int a, int b, int r);
        longint base, p, c, best;
        longint volts[5];
        int pick;
        volts[0] = a;
        volts[1] = a + b;
        volts[2] = -a;
        volts[3] = -(a + b);
        volts[4] = 0;
        base = ci - floor_div(longint'(B_DAMP) * ci);
        best = -1;
        pick = 4;
        for (int n = 0; n < 5; n++) begin
            p = base + floor_div(longint'(B_STEP) * volts[n]);
            if (p > 32767) p = 32767;
            if (p < -32768) p = -32768;
            c = p - r;
            if (c < 0) c = -c;
            c = c * B_WEIGHT;
            if (best < 0 || c < best) begin
                best = c;
                pick = n;
            end
        end
        return pick;
    endfunction

    // cycle-by-cycle reference model and comparison
    int   m_cnt = 0;
    int   m_pend = 4;
    logic e_done = 1'b0;
    int   e_lvl = 4;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            e_done = 1'b0;
            e_lvl  = 4;
        end else begin
            e_done = 1'b0;
            if (m_cnt > 0) begin
                if (m_cnt == 1) begin
                    e_done = 1'b1;
                    e_lvl  = m_pend;
                end
                m_cnt--;
            end else if (start) begin
                m_pend = ref_pick(int'(i_in), int'(v1), int'(v2), int'(iref));
                m_cnt  = 5;
            end
        end
        #1;
        if (checking) begin
            total++;
            if (done !== e_done || int'(level) != e_lvl) begin
                bad++;
                $display("FAIL %s: done=%0b level=%0d expected done=%0b level=%0d",
                         cur_tag, done, level, e_done, e_lvl);
            end
            if (done === 1'b1) n_done++;
        end
    end

    task automatic check_eq(input int got, input int exp, input string tag);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic eval_once(input int ci, input int a, input int b, input int r,
                             input int hand, input string tag);
        @(negedge clk);
        cur_tag = tag;
        i_in = 16'(ci); v1 = 16'(a); v2 = 16'(b); iref = 16'(r);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check_eq(int'(level), hand, tag);
    endtask

    initial begin : watchdog
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checking = 1'b1;
        @(negedge clk);
        // R8: reset values
        check_eq(int'(level), 4, "R8 reset level");
        check_eq(int'(done), 0, "R8 reset done");

        // R1: candidate set and measured voltages
        eval_once(0, 400, 400, 190, 1, "R1 sum level");
        eval_once(0, 400, 400, -300, 3, "R1 negative sum");
        eval_once(0, 400, 400, 10, 4, "R1 zero level");
        eval_once(0, 100, 700, 180, 1, "R1 uses vc2");
        eval_once(0, 100, 700, 20, 0, "R1 single cap");

        // R4: ties go to the lowest code
        eval_once(0, 400, 400, 150, 0, "R4 tie 0/1");
        eval_once(0, 400, 400, -150, 2, "R4 tie 2/3");
        eval_once(0, 400, 400, 50, 0, "R4 tie 0/4");
        eval_once(0, 400, 400, -50, 2, "R4 tie 2/4");

        // R2: damping term and floor rounding
        eval_once(1600, 400, 400, 1460, 4, "R2 damped zero");
        eval_once(1600, 400, 400, 1420, 2, "R2 damped neg");
        eval_once(-1601, 3, 3, -1501, 2, "R2 floor rounding a");
        eval_once(-1601, 3, 3, -1502, 3, "R2 floor rounding b");

        // R9 and R3: clamped predictions, full-scale errors
        eval_once(32000, 32767, 32767, 32767, 0, "R9 clamp high");
        eval_once(-32768, 32767, 32767, -32768, 2, "R9 clamp low");
        eval_once(32000, 32767, 32767, -32768, 3, "R3 large error");

        // R6: start and new inputs during an evaluation are ignored
        d0 = n_done;
        @(negedge clk);
        cur_tag = "R6 busy start";
        i_in = 0; v1 = 400; v2 = 400; iref = 190;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        iref = -300; v1 = 1000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check_eq(int'(level), 1, "R6 result of first capture");
        check_eq(n_done - d0, 1, "R6 single done");

        // R6/R5: held start is accepted every sixth edge
        d0 = n_done;
        cur_tag = "R6 held start";
        i_in = 0; v1 = 400; v2 = 400; iref = -300;
        start = 1'b1;
        repeat (24) @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        check_eq(n_done - d0, 4, "R6 held start done count");

        // R8: reset abandons an evaluation in flight
        d0 = n_done;
        cur_tag = "R8 mid reset";
        iref = 190;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        check_eq(n_done - d0, 0, "R8 no done after reset");
        check_eq(int'(level), 4, "R8 level after reset");

        // R5/R7: random decisions compared every clock against the model
        cur_tag = "R5 random";
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (k % 2 == 0) begin
                i_in = 16'($urandom_range(0, 4000)) - 16'sd2000;
                v1   = 16'($urandom_range(0, 1500));
                v2   = 16'($urandom_range(0, 1500));
                iref = 16'($urandom_range(0, 4000)) - 16'sd2000;
            end else begin
                i_in = 16'($urandom);
                v1   = 16'($urandom);
                v2   = 16'($urandom);
                iref = 16'($urandom);
            end
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (4 + ($urandom % 4)) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        check_eq(int'(level) <= 4 ? 1 : 0, 1, "R7 code range");

        checking = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule